// File: doc/BRIEF.md
# Daisy-Chain Serial Position Identifier

Each memory device on a daisy-chained sideband bus contains one copy of this block. A controller pulls a shared reset line high and then low. Each device then works out its own index along the chain from timing alone. The serial clock drives the block, and every input is sampled on its rising edge.

After a qualified reset release, the block counts clock edges until its serial input is first seen low. That count becomes the device's 6-bit position identifier, and a valid flag rises with it. The serial output follows a simple rule. It goes high while reset is held. It drops low in the same edge that the serial input is found low. The next device therefore sees its falling edge exactly one cycle later, so each device down the chain captures a number one larger than its upstream neighbour. The identifier lets later addressed transfers select one device. The framing of those transfers is not part of this block.

Top module: `serial_id_assign`

## Requirements
- R1: A release of `rst_line` is honoured only if `rst_line` was sampled high on at least MIN_HIGH (2) consecutive rising edges before the first low sample. After a shorter pulse, no identifier is captured, `id_valid` stays 0 and `sdo` stays 1 even when `sdi` goes low.
- R2: On the first rising edge that samples `rst_line` high, `sdo` becomes 1 and stays 1 while `rst_line` is held high.
- R3: After a qualified release, `sdo` becomes 0 on the same edge that first samples `sdi` low. It stays 0 until `rst_line` is next sampled high.
- R4: `dev_id` equals the number of rising edges from the release edge (the first low sample of `rst_line`) to the edge that first samples `sdi` low. If `sdi` is already low on the release edge, the value is 0. `id_valid` becomes 1 on the capture edge.
- R5: In a chain where each `sdo` feeds the next device's `sdi`, device k captures d+k, where d is the first device's count.
- R6: Any rising edge that samples `rst_line` high clears `dev_id` to 0 and `id_valid` to 0.
- R7: Once an identifier is captured, later changes of `sdi` leave `dev_id`, `id_valid` and `sdo` unchanged until `rst_line` is next sampled high.
- R8: If `sdi` is still high when the count reaches 63 (all ones), the block stops counting. `id_valid` stays 0 and `sdo` stays 1 until the next reset. A low `sdi` seen at count 63 still captures 63.
- R9: While `srst` is high, `sdo`, `dev_id` and `id_valid` are all 0.
- R10: A later qualified reset sequence rearms the block, and it captures a new identifier from the new timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bus clock; all sampling on its rising edge |
| srst | input | 1 | Synchronous active-high local reset |
| rst_line | input | 1 | Shared chain reset line from the controller |
| sdi | input | 1 | Serial input from the upstream device or the controller |
| sdo | output | 1 | Serial output to the downstream device |
| dev_id | output | ID_W (6) | Captured position identifier |
| id_valid | output | 1 | High once an identifier has been captured |

## Verification
The hardest case to reach is the saturation boundary. A device must be far enough down the chain that its count passes 63, while its upstream neighbours still capture 61, 62 and 63. The bench delays the controller's falling edge by 61 and 63 cycles on a four-device chain, so the last devices run off the end of the range. In the same runs, the first devices land exactly on the maximum. Two more cases need the reset line shaped on purpose: a reset held for exactly the minimum two samples, and one held for a single sample.

// File: rtl/sid_pkg.sv
package sid_pkg;

    localparam int ID_W_DEF     = 6;
    localparam int MIN_HIGH_DEF = 2;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HELD    = 3'd1,
        ST_COUNT   = 3'd2,
        ST_DONE    = 3'd3,
        ST_EXPIRED = 3'd4
    } sid_state_e;

    typedef struct packed {
        logic start;
        logic step;
        logic capture;
        logic cap_zero;
    } sid_ctrl_t;

endpackage

// File: rtl/sid_rst_qual.sv
module sid_rst_qual #(
    parameter int MIN_HIGH = sid_pkg::MIN_HIGH_DEF
) (
    input  logic clk,
    input  logic srst,
    input  logic rst_line,
    output logic release_ok
);
    localparam int HW = $clog2(MIN_HIGH + 1);
    localparam logic [HW-1:0] HI_LIM = HW'(MIN_HIGH);

    logic [HW-1:0] hi_cnt;

    // consecutive high samples, saturating at the qualifying length
    always_ff @(posedge clk) begin
        if (srst) begin
            hi_cnt <= '0;
        end else if (rst_line) begin
            if (hi_cnt < HI_LIM)
                hi_cnt <= hi_cnt + 1'b1;
        end else begin
            hi_cnt <= '0;
        end
    end

    assign release_ok = !rst_line && (hi_cnt >= HI_LIM);

endmodule

// File: rtl/sid_pos_counter.sv
module sid_pos_counter #(
    parameter int ID_W = sid_pkg::ID_W_DEF
) (
    input  logic            clk,
    input  logic            srst,
    input  logic            start,
    input  logic            step,
    output logic [ID_W-1:0] cnt,
    output logic            at_max
);
    localparam logic [ID_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (srst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= ID_W'(1);
        end else if (step && !at_max) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_max = (cnt == CNT_MAX);

endmodule

// File: rtl/sid_ctrl_fsm.sv
module sid_ctrl_fsm
    import sid_pkg::*;
(
    input  logic       clk,
    input  logic       srst,
    input  logic       rst_line,
    input  logic       sdi,
    input  logic       release_ok,
    input  logic       at_max,
    output sid_ctrl_t  ctrl,
    output logic       sdo
);
    sid_state_e state, state_n;
    logic       sdo_n;

    always_comb begin
        state_n = state;
        sdo_n   = sdo;
        ctrl    = '0;
        if (rst_line) begin
            state_n = ST_HELD;
            sdo_n   = 1'b1;
        end else begin
            unique case (state)
                ST_HELD: begin
                    if (!release_ok) begin
                        state_n = ST_IDLE;
                    end else if (!sdi) begin
                        ctrl.capture  = 1'b1;
                        ctrl.cap_zero = 1'b1;
                        sdo_n         = 1'b0;
                        state_n       = ST_DONE;
                    end else begin
                        ctrl.start = 1'b1;
                        state_n    = ST_COUNT;
                    end
                end
                ST_COUNT: begin
                    if (!sdi) begin
                        ctrl.capture = 1'b1;
                        sdo_n        = 1'b0;
                        state_n      = ST_DONE;
                    end else if (at_max) begin
                        state_n = ST_EXPIRED;
                    end else begin
                        ctrl.step = 1'b1;
                    end
                end
                default: begin
                    state_n = state;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            state <= ST_IDLE;
            sdo   <= 1'b0;
        end else begin
            state <= state_n;
            sdo   <= sdo_n;
        end
    end

endmodule

// File: rtl/serial_id_assign.sv
module serial_id_assign
    import sid_pkg::*;
#(
    parameter int ID_W     = ID_W_DEF,
    parameter int MIN_HIGH = MIN_HIGH_DEF
) (
    input  logic            clk,
    input  logic            srst,
    input  logic            rst_line,
    input  logic            sdi,
    output logic            sdo,
    output logic [ID_W-1:0] dev_id,
    output logic            id_valid
);
    logic            release_ok;
    logic            at_max;
    logic [ID_W-1:0] pos_cnt;
    sid_ctrl_t       ctrl;

    sid_rst_qual #(.MIN_HIGH(MIN_HIGH)) u_qual (
        .clk        (clk),
        .srst       (srst),
        .rst_line   (rst_line),
        .release_ok (release_ok)
    );

    sid_pos_counter #(.ID_W(ID_W)) u_cnt (
        .clk    (clk),
        .srst   (srst),
        .start  (ctrl.start),
        .step   (ctrl.step),
        .cnt    (pos_cnt),
        .at_max (at_max)
    );

    sid_ctrl_fsm u_fsm (
        .clk        (clk),
        .srst       (srst),
        .rst_line   (rst_line),
        .sdi        (sdi),
        .release_ok (release_ok),
        .at_max     (at_max),
        .ctrl       (ctrl),
        .sdo        (sdo)
    );

    // identifier register: cleared by any reset sample, loaded on capture
    always_ff @(posedge clk) begin
        if (srst || rst_line) begin
            dev_id   <= '0;
            id_valid <= 1'b0;
        end else if (ctrl.capture) begin
            dev_id   <= ctrl.cap_zero ? '0 : pos_cnt;
            id_valid <= 1'b1;
        end
    end

endmodule

// File: rtl/serial_id_assign_chk.sv
module serial_id_assign_chk #(
    parameter int ID_W = 6
) (
    input logic            clk,
    input logic            srst,
    input logic            rst_line,
    input logic            sdo,
    input logic [ID_W-1:0] dev_id,
    input logic            id_valid
);
    // R2
    sdo_high_in_reset_chk: assert property (@(posedge clk) disable iff (srst)
        rst_line |=> sdo);

    // R6
    clear_on_reset_chk: assert property (@(posedge clk) disable iff (srst)
        rst_line |=> (!id_valid && dev_id == '0));

    // R7
    id_hold_chk: assert property (@(posedge clk) disable iff (srst)
        (id_valid && !rst_line) |=> (id_valid && $stable(dev_id)));

    // R3
    sdo_fall_capture_chk: assert property (@(posedge clk) disable iff (srst)
        $fell(sdo) |-> $rose(id_valid));

    // R4
    capture_drops_sdo_chk: assert property (@(posedge clk) disable iff (srst)
        $rose(id_valid) |-> !sdo);
endmodule

bind serial_id_assign serial_id_assign_chk #(.ID_W(ID_W)) u_chk (
    .clk      (clk),
    .srst     (srst),
    .rst_line (rst_line),
    .sdo      (sdo),
    .dev_id   (dev_id),
    .id_valid (id_valid)
);

// File: tb/tb_serial_id_assign.sv
module tb_serial_id_assign;
    localparam int N    = 4;
    localparam int ID_W = 6;
    localparam int MAXV = 63;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic srst, rst_line, sdi0;
    logic [N:0]             link;
    logic [N-1:0][ID_W-1:0] ids;
    logic [N-1:0]           vld;
    assign link[0] = sdi0;

    serial_id_assign #(.ID_W(ID_W), .MIN_HIGH(2)) dut (
        .clk(clk), .srst(srst), .rst_line(rst_line), .sdi(link[0]),
        .sdo(link[1]), .dev_id(ids[0]), .id_valid(vld[0]));

    for (genvar k = 1; k < N; k++) begin : g_dn
        serial_id_assign #(.ID_W(ID_W), .MIN_HIGH(2)) u_dev (
            .clk(clk), .srst(srst), .rst_line(rst_line), .sdi(link[k]),
            .sdo(link[k+1]), .dev_id(ids[k]), .id_valid(vld[k]));
    end

    typedef struct {
        int    dev;
        int    exp_id;
        bit    exp_valid;
        string req;
    } exp_t;

    exp_t q[$];
    event chk_ev;
    int   nchk  = 0;
    int   nfail = 0;
    bit   done  = 1'b0;

    // monitor: pops expected items and compares against the chain
    initial begin
        exp_t e;
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                e = q.pop_front();
                nchk++;
                if (vld[e.dev] !== e.exp_valid ||
                    (e.exp_valid && ids[e.dev] !== e.exp_id[ID_W-1:0])) begin
                    nfail++;
                    $display("FAIL %s dev%0d: valid=%0b id=%0d, expected valid=%0b id=%0d",
                             e.req, e.dev, vld[e.dev], ids[e.dev], e.exp_valid, e.exp_id);
                end
            end
        end
    end

    task automatic push_chain(int base, string req);
        for (int k = 0; k < N; k++) begin
            exp_t e;
            e.dev       = k;
            e.exp_id    = base + k;
            e.exp_valid = (base + k) <= MAXV;
            e.req       = req;
            q.push_back(e);
        end
        -> chk_ev;
        #1;
    endtask

    task automatic push_invalid(string req);
        for (int k = 0; k < N; k++) begin
            exp_t e;
            e.dev = k; e.exp_id = 0; e.exp_valid = 1'b0; e.req = req;
            q.push_back(e);
        end
        -> chk_ev;
        #1;
    endtask

    task automatic check_bit(string req, string what, logic act, logic exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
        end
    endtask

    // driver: reset pulse of 'hold' samples, first sdi low 'delay' edges after release
    task automatic run_chain(int hold, int delay, string req);
        @(negedge clk);
        rst_line = 1'b1;
        sdi0     = 1'b1;
        repeat (hold) @(negedge clk);
        rst_line = 1'b0;
        if (delay == 0) begin
            sdi0 = 1'b0;
        end else begin
            repeat (delay) @(negedge clk);
            sdi0 = 1'b0;
        end
        repeat (N + 4) @(negedge clk);
        push_chain(delay, req);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        srst = 1'b1; rst_line = 1'b0; sdi0 = 1'b1;
        repeat (3) @(negedge clk);
        srst = 1'b0;
        @(negedge clk);
        // R9 reset state
        push_invalid("R9");
        check_bit("R9", "sdo after srst", link[1], 1'b0);

        // R2: sdo rises on the first high sample
        rst_line = 1'b1;
        check_bit("R2", "sdo before edge", link[1], 1'b0);
        @(negedge clk);
        check_bit("R2", "dev0 sdo", link[1], 1'b1);
        check_bit("R2", "dev1 sdo", link[2], 1'b1);
        @(negedge clk);
        rst_line = 1'b0;
        sdi0     = 1'b0;
        @(negedge clk);
        // R3: dev0 drops on the release edge, dev1 one edge later
        check_bit("R3", "dev0 sdo drop", link[1], 1'b0);
        check_bit("R3", "dev1 sdo still high", link[2], 1'b1);
        @(negedge clk);
        check_bit("R3", "dev1 sdo drop", link[2], 1'b0);
        repeat (4) @(negedge clk);
        // R4 (dev0 = 0), R5 (chain 0..3), R1 boundary of exactly two samples
        push_chain(0, "R4/R5");

        // R7: sdi toggling after capture changes nothing
        sdi0 = 1'b1;
        repeat (3) @(negedge clk);
        sdi0 = 1'b0;
        repeat (3) @(negedge clk);
        check_bit("R7", "sdo stays low", link[1], 1'b0);
        push_chain(0, "R7");

        run_chain(3, 5, "R5");
        run_chain(2, 2, "R10");
        run_chain(4, 61, "R8");
        check_bit("R8", "expired dev3 sdo", link[4], 1'b1);
        run_chain(2, 63, "R8");

        // R6: a reset sample clears a captured id
        @(negedge clk);
        rst_line = 1'b1;
        sdi0     = 1'b1;
        @(negedge clk);
        check_bit("R6", "dev0 valid cleared", vld[0], 1'b0);
        // R1: single-sample pulse is ignored
        rst_line = 1'b0;
        sdi0     = 1'b0;
        repeat (10) @(negedge clk);
        check_bit("R1", "dev0 sdo after short pulse", link[1], 1'b1);
        push_invalid("R1");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end
endmodule